// File: doc/BRIEF.md
# Resumable NMI Trap Controller

This block is the part of a machine-mode trap unit that handles resumable non-maskable interrupts. A vector of level-sensitive NMI request lines is sampled into pending bits. While the handler-active enable is set and any line is pending, the block redirects the hart to a fixed NMI interrupt vector in machine mode. Before it does so it saves the interrupted PC, the interrupted privilege and the line index into its own save registers. This leaves the ordinary machine trap registers untouched, so the interrupted context can be resumed.

While the enable is clear, the hart is inside the NMI handler. No interrupt of any kind may be taken. A synchronous exception raised inside the handler is kept in machine mode and sent to a separate NMI exception vector. The pipeline feeds the block its current privilege and PC, an exception strobe and the instruction being retired. The block decodes the NMI return instruction itself and either produces the return redirect or reports a fault cause. Its four save registers sit behind a simple CSR port with a combinational read and a synchronous write.

Every redirect and every fault appears as a one-cycle pulse on the clock edge after the event that caused it.

Top module: `nmi_trap_ctrl`

## Requirements
- R1: The CSR port maps four registers at these addresses: 0x350 scratch, 0x351 saved PC, 0x352 cause and 0x353 status. `csr_hit` is high for exactly these four addresses. The scratch, saved PC and cause registers read back the full XLEN value written to them.
- R2: A write to the status register (0x353) keeps only bits 12:11, which hold the previous-privilege field. All other bits of the status register read as zero.
- R3: Each pending bit copies its NMI line one clock later. A line that rises and falls while the handler is active leaves nothing pending after the return, and no NMI is taken.
- R4: When the enable is set and a line is pending, the block produces a one-cycle redirect with kind 0, PC equal to `IRQ_VEC` (default 0x1000) and privilege 3. The redirect appears two clock edges after the line rises. When several lines are pending, the lowest-numbered one is taken.
- R5: On NMI entry the block does four things: it stores `cur_pc` in the saved PC register, it stores the line index in the cause register with no interrupt flag, it stores `cur_priv` in status bits 12:11, and it clears the enable.
- R6: `irq_allow` is high only while the enable is set and nothing is pending. While the enable is clear, a line that is held high causes no redirect.
- R7: While the enable is clear, `sdeleg_allow` is low, and `exc_req` produces a redirect of kind 1 to `EXC_VEC` (default 0x1000) in privilege 3. While the enable is set, `exc_req` produces no redirect.
- R8: The return instruction 0x70200073 in machine mode produces a redirect of kind 2. Its PC is the saved PC and its privilege is status bits 12:11. It also sets the enable.
- R9: The return instruction fails when the hart is not in machine mode. The failure is a fault pulse with cause 2 (illegal instruction), no redirect, and no change to the enable.
- R10: With `HAS_COMPRESSED`=0, a return whose saved PC has nonzero bits 1:0 fails with a fault of cause 0 (misaligned address).
- R11: With `PMP_RULES`=0, a return to a privilege below 3 fails with a fault of cause 2.
- R12: With `HAS_RNMI`=0, the block has no NMI function:
  - `csr_hit` is low and reads return zero;
  - no NMI is taken;
  - the return instruction faults with cause 2.
- R13: A CSR write that falls in the same cycle as an NMI entry is dropped.
- R14: After reset the enable is set, the four registers read zero, and no redirect or fault is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_lines | input | NUM_NMI | Level-sensitive NMI request lines |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_pc | input | XLEN | PC of the instruction to interrupt or resume |
| exc_req | input | 1 | Synchronous exception raised this cycle |
| instr_valid | input | 1 | `instr` is being retired |
| instr | input | 32 | Retiring instruction word |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| csr_hit | output | 1 | Address is one of the NMI registers |
| irq_allow | output | 1 | Ordinary interrupts may be taken |
| sdeleg_allow | output | 1 | Exceptions may be delegated to S-mode |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_kind | output | 2 | 0 entry, 1 handler exception, 2 return |
| redir_pc | output | XLEN | Redirect target |
| redir_priv | output | 2 | Privilege after the redirect |
| fault_valid | output | 1 | One-cycle return-fault pulse |
| fault_cause | output | 4 | 0 misaligned, 2 illegal |

## Verification
The checker assumes that the pipeline presents `exc_req` and the return instruction only as single-cycle strobes. It also assumes that `cur_priv` never carries the reserved value 2. The bench keeps within these limits: it raises each strobe for exactly one clock and drives only the values 0, 1 and 3 on `cur_priv`. Under these conditions the checker requires the following:
- the enable falls only together with an entry redirect;
- the enable rises only together with a return redirect;
- a redirect and a fault never appear together.

// File: rtl/nmi_pkg.sv
`timescale 1ns/1ps
// Shared constants for the resumable NMI trap controller.
// Assumes the privilege encoding 0 = U, 1 = S, 3 = M.
package nmi_pkg;
    localparam logic [1:0]  PRIV_M       = 2'b11;
    localparam logic [11:0] CSR_SCRATCH  = 12'h350;
    localparam logic [11:0] CSR_EPC      = 12'h351;
    localparam logic [11:0] CSR_CAUSE    = 12'h352;
    localparam logic [11:0] CSR_STATUS   = 12'h353;
    localparam logic [31:0] RET_OPCODE   = 32'h7020_0073;
    localparam int          MPP_LSB      = 11;
    localparam logic [3:0]  FC_MISALIGN  = 4'd0;
    localparam logic [3:0]  FC_ILLEGAL   = 4'd2;

    typedef enum logic [1:0] {
        RK_ENTRY = 2'd0,
        RK_EXC   = 2'd1,
        RK_RET   = 2'd2
    } redir_kind_e;
endpackage

// File: rtl/nmi_pend_enc.sv
`timescale 1ns/1ps
// Pending register and lowest-index priority encoder.
// Each pending bit copies its line one clock later.
// Assumes the lines are synchronous to clk.
module nmi_pend_enc #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  lines,
    output logic          pend_any,
    output logic [IW-1:0] pend_idx
);
    logic [N-1:0] pend_q;

    // Sample the line levels into the pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= lines;
    end

    // Find the lowest-numbered pending line.
    always_comb begin
        pend_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_q[i]) pend_idx = IW'(i);
        end
    end

    assign pend_any = |pend_q;
endmodule

// File: rtl/nmi_csr_bank.sv
`timescale 1ns/1ps
// Save registers for the NMI: scratch, saved PC, cause and status.
// The status register holds only the previous-privilege field.
// An entry update takes priority over a software write in the same cycle.
module nmi_csr_bank #(
    parameter int XLEN     = 32,
    parameter bit HAS_RNMI = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [11:0]     addr,
    input  logic [XLEN-1:0] wdata,
    input  logic            entry,
    input  logic [XLEN-1:0] entry_pc,
    input  logic [XLEN-1:0] entry_cause,
    input  logic [1:0]      entry_priv,
    output logic            hit,
    output logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] epc,
    output logic [1:0]      mpp
);
    import nmi_pkg::*;

    logic [XLEN-1:0] scratch_q, epc_q, cause_q;
    logic [1:0]      mpp_q;
    logic [XLEN-1:0] status_word;

    assign hit = HAS_RNMI && (addr[11:2] == CSR_SCRATCH[11:2]);

    // Update the registers from a trap entry or a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
            epc_q     <= '0;
            cause_q   <= '0;
            mpp_q     <= '0;
        end else if (entry) begin
            epc_q   <= entry_pc;
            cause_q <= entry_cause;
            mpp_q   <= entry_priv;
        end else if (wr_en && hit) begin
            case (addr[1:0])
                CSR_SCRATCH[1:0]: scratch_q <= wdata;
                CSR_EPC[1:0]:     epc_q     <= wdata;
                CSR_CAUSE[1:0]:   cause_q   <= wdata;
                default:          mpp_q     <= wdata[MPP_LSB+1:MPP_LSB];
            endcase
        end
    end

    // Build the status word and the read mux.
    always_comb begin
        status_word = '0;
        status_word[MPP_LSB+1:MPP_LSB] = mpp_q;
        rdata = '0;
        if (hit) begin
            case (addr[1:0])
                CSR_SCRATCH[1:0]: rdata = scratch_q;
                CSR_EPC[1:0]:     rdata = epc_q;
                CSR_CAUSE[1:0]:   rdata = cause_q;
                default:          rdata = status_word;
            endcase
        end
    end

    assign epc = epc_q;
    assign mpp = mpp_q;
endmodule

// File: rtl/nmi_ret_unit.sv
`timescale 1ns/1ps
// Decodes the NMI return instruction and checks whether it is legal.
// The checks are made in order: feature present and machine mode,
// then target alignment, then the privilege the hart returns to.
module nmi_ret_unit #(
    parameter bit HAS_RNMI       = 1'b1,
    parameter bit HAS_COMPRESSED = 1'b0,
    parameter int PMP_RULES      = 0
) (
    input  logic        instr_valid,
    input  logic [31:0] instr,
    input  logic [1:0]  cur_priv,
    input  logic [1:0]  epc_lo,
    input  logic [1:0]  mpp,
    output logic        ret_req,
    output logic        ret_ok,
    output logic        ret_fault,
    output logic [3:0]  ret_cause
);
    import nmi_pkg::*;

    assign ret_req = instr_valid && (instr == RET_OPCODE);

    // Classify the return as legal or as one of the faults.
    always_comb begin
        ret_ok    = 1'b0;
        ret_fault = 1'b0;
        ret_cause = FC_ILLEGAL;
        if (ret_req) begin
            if (!HAS_RNMI || cur_priv != PRIV_M) begin
                ret_fault = 1'b1;
            end else if (!HAS_COMPRESSED && epc_lo != 2'b00) begin
                ret_fault = 1'b1;
                ret_cause = FC_MISALIGN;
            end else if (PMP_RULES == 0 && mpp != PRIV_M) begin
                ret_fault = 1'b1;
            end else begin
                ret_ok = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nmi_trap_ctrl.sv
`timescale 1ns/1ps
// Resumable NMI trap controller (top).
// It takes NMIs ahead of ordinary interrupts and keeps exceptions raised
// inside the handler in machine mode, sending them to a separate vector.
// It executes the NMI return instruction.
// Assumes exc_req and the return instruction are single-cycle strobes.
// All redirects and faults are registered one-cycle pulses.
module nmi_trap_ctrl #(
    parameter int              XLEN           = 32,
    parameter int              NUM_NMI        = 4,
    parameter logic [XLEN-1:0] IRQ_VEC        = 'h1000,
    parameter logic [XLEN-1:0] EXC_VEC        = 'h1000,
    parameter bit              HAS_RNMI       = 1'b1,
    parameter bit              HAS_COMPRESSED = 1'b0,
    parameter int              PMP_RULES      = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_NMI-1:0] nmi_lines,
    input  logic [1:0]         cur_priv,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic               exc_req,
    input  logic               instr_valid,
    input  logic [31:0]        instr,
    input  logic               csr_we,
    input  logic [11:0]        csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               csr_hit,
    output logic               irq_allow,
    output logic               sdeleg_allow,
    output logic               redir_valid,
    output logic [1:0]         redir_kind,
    output logic [XLEN-1:0]    redir_pc,
    output logic [1:0]         redir_priv,
    output logic               fault_valid,
    output logic [3:0]         fault_cause
);
    import nmi_pkg::*;

    localparam int IDX_W = (NUM_NMI > 1) ? $clog2(NUM_NMI) : 1;

    logic             nmi_en;
    logic             pend_any;
    logic [IDX_W-1:0] pend_idx;
    logic [XLEN-1:0]  epc;
    logic [1:0]       mpp;
    logic             ret_req, ret_ok, ret_fault;
    logic [3:0]       ret_cause;
    logic             take_nmi, exc_in_handler;

    nmi_pend_enc #(.N(NUM_NMI), .IW(IDX_W)) pend_i (
        .clk(clk), .rst_n(rst_n), .lines(nmi_lines),
        .pend_any(pend_any), .pend_idx(pend_idx)
    );

    nmi_csr_bank #(.XLEN(XLEN), .HAS_RNMI(HAS_RNMI)) csr_i (
        .clk(clk), .rst_n(rst_n), .wr_en(csr_we), .addr(csr_addr),
        .wdata(csr_wdata), .entry(take_nmi), .entry_pc(cur_pc),
        .entry_cause(XLEN'(pend_idx)), .entry_priv(cur_priv),
        .hit(csr_hit), .rdata(csr_rdata), .epc(epc), .mpp(mpp)
    );

    nmi_ret_unit #(.HAS_RNMI(HAS_RNMI), .HAS_COMPRESSED(HAS_COMPRESSED),
                   .PMP_RULES(PMP_RULES)) ret_i (
        .instr_valid(instr_valid), .instr(instr), .cur_priv(cur_priv),
        .epc_lo(epc[1:0]), .mpp(mpp), .ret_req(ret_req), .ret_ok(ret_ok),
        .ret_fault(ret_fault), .ret_cause(ret_cause)
    );

    assign take_nmi       = HAS_RNMI && nmi_en && pend_any && !exc_req && !ret_req;
    assign exc_in_handler = HAS_RNMI && exc_req && !nmi_en;
    assign irq_allow      = !HAS_RNMI || (nmi_en && !pend_any);
    assign sdeleg_allow   = !HAS_RNMI || nmi_en;

    // Choose the event with the highest priority and register the redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_en      <= HAS_RNMI;
            redir_valid <= 1'b0;
            redir_kind  <= RK_ENTRY;
            redir_pc    <= '0;
            redir_priv  <= PRIV_M;
            fault_valid <= 1'b0;
            fault_cause <= '0;
        end else begin
            redir_valid <= 1'b0;
            fault_valid <= 1'b0;
            if (exc_in_handler) begin
                redir_valid <= 1'b1;
                redir_kind  <= RK_EXC;
                redir_pc    <= EXC_VEC;
                redir_priv  <= PRIV_M;
            end else if (ret_ok) begin
                redir_valid <= 1'b1;
                redir_kind  <= RK_RET;
                redir_pc    <= epc;
                redir_priv  <= mpp;
                nmi_en      <= 1'b1;
            end else if (ret_fault) begin
                fault_valid <= 1'b1;
                fault_cause <= ret_cause;
            end else if (take_nmi) begin
                redir_valid <= 1'b1;
                redir_kind  <= RK_ENTRY;
                redir_pc    <= IRQ_VEC;
                redir_priv  <= PRIV_M;
                nmi_en      <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/nmi_trap_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for nmi_trap_ctrl, attached to every instance by bind.
// Assumes single-cycle strobes on exc_req and on the return instruction.
module nmi_trap_ctrl_chk #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] IRQ_VEC  = 'h1000,
    parameter logic [XLEN-1:0] EXC_VEC  = 'h1000,
    parameter bit              HAS_RNMI = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            nmi_en,
    input logic            redir_valid,
    input logic [1:0]      redir_kind,
    input logic [XLEN-1:0] redir_pc,
    input logic [1:0]      redir_priv,
    input logic            fault_valid,
    input logic            irq_allow
);
    // R4
    entry_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && redir_kind == 2'd0) |-> (redir_pc == IRQ_VEC && redir_priv == 2'b11 && !nmi_en));

    // R7
    exc_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && redir_kind == 2'd1) |-> (redir_pc == EXC_VEC && redir_priv == 2'b11));

    // R5
    en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_en) |-> (redir_valid && redir_kind == 2'd0));

    // R8
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_en) |-> (redir_valid && redir_kind == 2'd2));

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_allow && HAS_RNMI) |-> nmi_en);

    // R9
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(redir_valid && fault_valid));
endmodule

bind nmi_trap_ctrl nmi_trap_ctrl_chk #(
    .XLEN(XLEN), .IRQ_VEC(IRQ_VEC), .EXC_VEC(EXC_VEC), .HAS_RNMI(HAS_RNMI)
) chk_i (.*);

// File: tb/nmi_trap_ctrl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a table walk over NMI entries, then directed tests.
module nmi_trap_ctrl_tb_top;
    localparam logic [31:0] RET_OP = 32'h7020_0073;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  nmi_lines;
    logic [1:0]  cur_priv;
    logic [31:0] cur_pc;
    logic        exc_req, instr_valid, csr_we;
    logic [31:0] instr, csr_wdata;
    logic [11:0] csr_addr;
    logic [31:0] csr_rdata, redir_pc;
    logic        csr_hit, irq_allow, sdeleg_allow, redir_valid, fault_valid;
    logic [1:0]  redir_kind, redir_priv;
    logic [3:0]  fault_cause;
    logic [31:0] off_rdata, off_pc;
    logic        off_hit, off_irq, off_sdeleg, off_redir, off_fault;
    logic [1:0]  off_kind, off_priv;
    logic [3:0]  off_cause;

    int checks = 0;
    int errors = 0;
    logic [31:0] v;

    always #2 clk = ~clk;

    nmi_trap_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .nmi_lines(nmi_lines), .cur_priv(cur_priv),
        .cur_pc(cur_pc), .exc_req(exc_req), .instr_valid(instr_valid),
        .instr(instr), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_hit(csr_hit),
        .irq_allow(irq_allow), .sdeleg_allow(sdeleg_allow),
        .redir_valid(redir_valid), .redir_kind(redir_kind),
        .redir_pc(redir_pc), .redir_priv(redir_priv),
        .fault_valid(fault_valid), .fault_cause(fault_cause)
    );

    nmi_trap_ctrl #(.HAS_RNMI(1'b0)) dut_off_i (
        .clk(clk), .rst_n(rst_n), .nmi_lines(nmi_lines), .cur_priv(cur_priv),
        .cur_pc(cur_pc), .exc_req(exc_req), .instr_valid(instr_valid),
        .instr(instr), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(off_rdata), .csr_hit(off_hit),
        .irq_allow(off_irq), .sdeleg_allow(off_sdeleg),
        .redir_valid(off_redir), .redir_kind(off_kind),
        .redir_pc(off_pc), .redir_priv(off_priv),
        .fault_valid(off_fault), .fault_cause(off_cause)
    );

    // Table fields: lines[39:36] priv[35:34] pc[33:2] expected cause[1:0]
    localparam logic [39:0] VEC [4] = '{
        {4'b0001, 2'b11, 32'h0000_0100, 2'd0},
        {4'b0110, 2'b00, 32'h0000_2000, 2'd1},
        {4'b1000, 2'b01, 32'h0000_8004, 2'd3},
        {4'b1111, 2'b11, 32'h0000_FFFC, 2'd0}
    };

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] val);
        csr_addr = a;
        #0.2;
        val = csr_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        csr_addr = a; csr_wdata = d; csr_we = 1'b1;
        tick;
        csr_we = 1'b0;
    endtask

    task automatic do_ret;
        instr = RET_OP; instr_valid = 1'b1;
        tick;
        instr_valid = 1'b0;
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; nmi_lines = '0; cur_priv = 2'b11; cur_pc = '0;
        exc_req = 1'b0; instr_valid = 1'b0; instr = '0; csr_we = 1'b0;
        csr_addr = '0; csr_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick;

        // R14 reset state
        chk("R14 redir", redir_valid, 0);
        chk("R14 fault", fault_valid, 0);
        chk("R14 enable", sdeleg_allow, 1);
        rd(12'h351, v); chk("R14 epc", v, 0);
        rd(12'h353, v); chk("R14 status", v, 0);

        // R4 R5 R8 table walk over entry patterns
        for (int i = 0; i < 4; i++) begin
            cur_priv = VEC[i][35:34]; cur_pc = VEC[i][33:2]; nmi_lines = VEC[i][39:36];
            tick; tick;
            chk("R4 valid", redir_valid, 1);
            chk("R4 kind", redir_kind, 0);
            chk("R4 pc", redir_pc, 32'h1000);
            chk("R4 priv", redir_priv, 3);
            nmi_lines = '0;
            rd(12'h352, v); chk("R4 cause", v, {30'd0, VEC[i][1:0]});
            rd(12'h351, v); chk("R5 epc", v, VEC[i][33:2]);
            rd(12'h353, v); chk("R5 mpp", v, {19'd0, VEC[i][35:34], 11'd0});
            chk("R5 irq blocked", irq_allow, 0);
            tick;
            chk("R4 pulse", redir_valid, 0);
            wr(12'h353, 32'h1800);
            cur_priv = 2'b11;
            do_ret;
            chk("R8 valid", redir_valid, 1);
            chk("R8 kind", redir_kind, 2);
            chk("R8 pc", redir_pc, VEC[i][33:2]);
            chk("R8 priv", redir_priv, 3);
            tick;
            chk("R8 enable", irq_allow, 1);
        end

        // R6 pending blocks ordinary interrupts; no retake inside handler
        nmi_lines = 4'b0100; tick;
        chk("R6 pending", irq_allow, 0);
        tick;
        chk("R6 entry", redir_valid, 1);
        tick; tick;
        chk("R6 no retake", redir_valid, 0);
        chk("R7 no deleg", sdeleg_allow, 0);

        // R7 exception inside handler
        exc_req = 1'b1; tick; exc_req = 1'b0;
        chk("R7 valid", redir_valid, 1);
        chk("R7 kind", redir_kind, 1);
        chk("R7 pc", redir_pc, 32'h1000);
        chk("R7 priv", redir_priv, 3);
        nmi_lines = '0; tick;

        // R3 a short pulse during the handler is not remembered
        nmi_lines = 4'b0010; tick; tick; nmi_lines = '0; tick; tick;
        wr(12'h351, 32'h40); wr(12'h353, 32'h1800);
        do_ret;
        chk("R3 ret", redir_pc, 32'h40);
        begin
            int seen = 0;
            for (int k = 0; k < 3; k++) begin
                tick;
                if (redir_valid) seen++;
            end
            chk("R3 no late NMI", seen, 0);
        end
        chk("R3 irq ok", irq_allow, 1);

        // R13 entry wins over a CSR write in the same cycle
        cur_pc = 32'h700; nmi_lines = 4'b0001; tick;
        wr(12'h351, 32'h55);
        chk("R13 entry", redir_valid, 1);
        rd(12'h351, v); chk("R13 epc", v, 32'h700);
        nmi_lines = '0;

        // R9 return outside machine mode
        cur_priv = 2'b01; do_ret;
        chk("R9 fault", fault_valid, 1);
        chk("R9 cause", fault_cause, 2);
        chk("R9 no redir", redir_valid, 0);
        chk("R9 still in handler", sdeleg_allow, 0);

        // R10 misaligned return target
        cur_priv = 2'b11;
        wr(12'h351, 32'h102); wr(12'h353, 32'h1800);
        do_ret;
        chk("R10 fault", fault_valid, 1);
        chk("R10 cause", fault_cause, 0);

        // R11 return to S-mode with no PMP rules
        wr(12'h351, 32'h104); wr(12'h353, 32'h0800);
        do_ret;
        chk("R11 fault", fault_valid, 1);
        chk("R11 cause", fault_cause, 2);
        chk("R11 no redir", redir_valid, 0);

        wr(12'h353, 32'h1800);
        do_ret;
        chk("R8 exit", redir_valid, 1);
        chk("R8 deleg", sdeleg_allow, 1);

        // R7 exception outside handler is not taken here
        exc_req = 1'b1; tick; exc_req = 1'b0;
        chk("R7 outside", redir_valid, 0);

        // R1 address map
        csr_addr = 12'h34F; #0.2; chk("R1 below", csr_hit, 0);
        csr_addr = 12'h354; #0.2; chk("R1 above", csr_hit, 0);
        csr_addr = 12'h350; #0.2; chk("R1 hit", csr_hit, 1);
        wr(12'h350, 32'hDEAD_BEEF);
        rd(12'h350, v); chk("R1 scratch", v, 32'hDEAD_BEEF);
        wr(12'h352, 32'h1234_5678);
        rd(12'h352, v); chk("R1 cause", v, 32'h1234_5678);

        // R2 status mask
        wr(12'h353, 32'hFFFF_FFFF);
        rd(12'h353, v); chk("R2 all ones", v, 32'h1800);
        wr(12'h353, 32'h0000_0800);
        rd(12'h353, v); chk("R2 S", v, 32'h0800);

        // R12 feature absent
        csr_addr = 12'h350; #0.2;
        chk("R12 hit", off_hit, 0);
        chk("R12 rdata", off_rdata, 0);
        nmi_lines = 4'b0001; tick; tick;
        chk("R12 no entry", off_redir, 0);
        nmi_lines = '0;
        cur_priv = 2'b11; do_ret;
        chk("R12 ret fault", off_fault, 1);
        chk("R12 ret cause", off_cause, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule